// File: doc/BRIEF.md
# Endpoint FIFO Access Controller

This block sits between a microcontroller register bus and four small per-endpoint byte FIFOs of a full-speed USB device. Firmware picks one endpoint through a configuration register. It claims that endpoint's FIFO by raising a request bit and moves bytes through a data register. It finishes a transfer with a direction/end bit whose sense depends on the transfer direction: held at 1 and dropped to 0 after a write, held at 0 and raised to 1 after a read. The transfer is committed on that edge while the request bit is still high.

A simplified packet-level host port pushes OUT/SETUP packets into output-pipe FIFOs and pops bytes of IN packets from input-pipe FIFOs. A pipe-direction register marks each endpoint as an input or an output pipe. Host traffic of the wrong direction is dropped without any effect. A firmware clear flushes the selected FIFO, and host reads of that endpoint then report an underrun error until firmware commits fresh data. Status flags (setup content, ready, zero-length packet), a data-toggle bit and two isochronous interrupt enables complete the register set. A bus reset clears the command/status register independently of the system reset.

Top module: `ep_fifo_ctrl`

## Requirements
- R1: A one-cycle `bus_rst` clears request, direction/end and toggle to 0 and flushes every FIFO, clearing the setup, zero-length and pending-packet state. Afterwards the command/status register (address 0) reads 0x00 for a selected output pipe, and the pipe-direction register is kept.
- R2: After `rst`, the pipe-direction register (address 2, bit k = endpoint k+1, 1 = input) reads 0x0D, and the configuration register (address 1) reads 0x00. The pipe-direction register is writable.
- R3: A FIFO holds at most 8 bytes, and host bytes beyond that are dropped. A data read from an empty FIFO returns 0x00.
- R4: Output pipe: after the host ends a packet, ready (bit 4) is 1. With request (bit 0) high, data-register reads (address 3) return the bytes in host order one cycle after the read strobe. A write that keeps request at 1 and raises direction/end (bit 1) from 0 to 1 releases the packet, and ready returns to 0.
- R5: Input pipe: ready is 1 while the FIFO is empty and uncommitted. With request and direction/end both 1, data writes store bytes. A write that keeps request at 1 and drops direction/end from 1 to 0 commits them. Host pops then return the bytes in order with `h_in_valid` one cycle later, and ready returns to 1 once the packet is drained.
- R6: Data-register accesses made while request is 0 have no effect: a read returns 0x00 and consumes nothing, and a write stores nothing.
- R7: Writing clear (bit 2, reads back 0) flushes the selected FIFO even when it is not ready. Host pops of that input pipe then raise `h_in_err` and never `h_in_valid`, until firmware commits a new packet.
- R8: The setup flag (bit 3) takes the value of `h_out_setup` at the end of each host packet. It keeps that value through firmware reads and the release, until the next packet ends.
- R9: The zero-length flag (bit 5) is set when the host ends a packet with no bytes. It is cleared only by a data-register read of that output pipe while request is 1.
- R10: The data-toggle bit (bit 6) is readable and writable and drives `h_data1`.
- R11: Host pushes and packet ends aimed at an input pipe, and host pops aimed at an output pipe, are ignored: no state changes, and neither `h_in_valid` nor `h_in_err` is raised.
- R12: `irq_iso_in` is high when configuration bit 2 is set and some input pipe is ready. `irq_iso_out` is high when configuration bit 3 is set and some output pipe holds a packet. The endpoint select is configuration bits 1:0, value k for endpoint k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_rst | input | 1 | Synchronous USB bus reset; clears command/status and flushes FIFOs |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | 0 command/status, 1 configuration, 2 pipe direction, 3 data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid the cycle after `reg_rd` |
| h_ep | input | 2 | Endpoint index for host operations |
| h_out_push | input | 1 | Host pushes one byte of an OUT/SETUP packet |
| h_out_byte | input | 8 | Byte pushed by the host |
| h_out_end | input | 1 | Host marks the end of the current packet |
| h_out_setup | input | 1 | Packet ending now is a setup command |
| h_in_pop | input | 1 | Host takes one byte of an IN packet |
| h_in_valid | output | 1 | Popped byte on `h_in_byte` is valid |
| h_in_byte | output | 8 | Byte returned to the host |
| h_in_err | output | 1 | Forced transmit error (underrun) after a clear |
| h_data1 | output | 1 | Data-toggle: 1 selects DATA1 |
| irq_iso_in | output | 1 | Isochronous IN pipe interrupt |
| irq_iso_out | output | 1 | Isochronous OUT pipe interrupt |

## Verification
Register writes and host strobes act on the next rising edge, and register read data and host pop responses (`h_in_valid`, `h_in_byte`, `h_in_err`) appear one edge after their strobe. The interrupt outputs are registered from FIFO and configuration state, so they follow the state-changing write by two edges. The bench drives every strobe on a falling edge for exactly one cycle and samples on the following falling edge. For interrupts it waits one extra falling edge. It sweeps packet lengths 1 through 8 in both directions with byte values computed from the length and position, so each check samples in the cycle its result is due.

// File: rtl/epf_pkg.sv
package epf_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    A_CSR  = 2'd0,
    A_CFG  = 2'd1,
    A_DIR  = 2'd2,
    A_DATA = 2'd3
  } reg_addr_e;

  // command/status bit positions
  localparam int B_REQ   = 0;
  localparam int B_TX    = 1;
  localparam int B_CLR   = 2;
  localparam int B_SETUP = 3;
  localparam int B_RDY   = 4;
  localparam int B_ZLP   = 5;
  localparam int B_TOG   = 6;

  // configuration bit positions
  localparam int C_IEN = 2;
  localparam int C_OEN = 3;
endpackage

// File: rtl/epf_buf.sv
module epf_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         is_in,
  input  logic                         push,
  input  logic [DW-1:0]                wdata,
  input  logic                         pop,
  input  logic                         host_end,
  input  logic                         host_setup,
  input  logic                         commit_in,
  input  logic                         commit_out,
  input  logic                         fw_touch,
  output logic [DW-1:0]                rdata,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic                         pkt,
  output logic                         setup,
  output logic                         zlp,
  output logic                         uflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push_ok, pop_ok;

  assign push_ok = push && (cnt < CW'(DEPTH));
  assign pop_ok  = pop && (cnt != '0);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; wptr <= '0; rptr <= '0;
      pkt <= 1'b0; setup <= 1'b0; zlp <= 1'b0; uflow <= 1'b0;
    end else if (flush) begin
      cnt <= '0; wptr <= '0; rptr <= '0;
      pkt <= 1'b0; uflow <= 1'b1;
    end else begin
      if (push_ok) wptr <= nxt(wptr);
      if (pop_ok)  rptr <= nxt(rptr);
      cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
      if (host_end) begin
        pkt   <= 1'b1;
        setup <= host_setup;
        zlp   <= (cnt == '0);
      end
      if (commit_in) begin
        pkt   <= 1'b1;
        uflow <= 1'b0;
      end
      if (commit_out) begin
        pkt <= 1'b0; cnt <= '0; wptr <= '0; rptr <= '0;
      end
      if (is_in && pop && cnt <= CW'(1)) pkt <= 1'b0;
      if (fw_touch) zlp <= 1'b0;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt == '0) && uflow && !pkt);

  assert_zlp_from_end_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(zlp) |-> $past(host_end));
endmodule

// File: rtl/ep_fifo_ctrl.sv
module ep_fifo_ctrl
  import epf_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int DEPTH  = 8,
  parameter logic [NUM_EP-1:0] DIR_RESET = 4'b1101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [1:0]        h_ep,
  input  logic              h_out_push,
  input  logic [DATA_W-1:0] h_out_byte,
  input  logic              h_out_end,
  input  logic              h_out_setup,
  input  logic              h_in_pop,
  output logic              h_in_valid,
  output logic [DATA_W-1:0] h_in_byte,
  output logic              h_in_err,
  output logic              h_data1,
  output logic              irq_iso_in,
  output logic              irq_iso_out
);
  localparam int SELW = $clog2(NUM_EP);
  localparam int CW   = $clog2(DEPTH+1);

  logic [SELW-1:0]   sel_q, h_ep_q, rsel_q;
  logic              ien_q, oen_q, req_q, tx_q, tog_q, rd_data_q;
  logic [NUM_EP-1:0] dir_q;
  logic [DATA_W-1:0] rdata_q;

  logic [NUM_EP-1:0] pkt_v, setup_v, zlp_v, uflow_v, full_v, empty_v, rdy_v;
  logic [DATA_W-1:0] buf_rd [NUM_EP];
  logic [CW-1:0]     cnt_a  [NUM_EP];

  logic csr_wr, cfg_wr, dir_wr, data_wr, data_rd;
  logic commit_in, commit_out, flush_sel, fw_push_ok, fw_pop_ok, fw_touch;
  logic h_push_ok, h_end_ok, h_pop_go, h_pop_data, h_err;

  assign csr_wr  = reg_wr && (reg_addr == A_CSR);
  assign cfg_wr  = reg_wr && (reg_addr == A_CFG);
  assign dir_wr  = reg_wr && (reg_addr == A_DIR);
  assign data_wr = reg_wr && (reg_addr == A_DATA);
  assign data_rd = reg_rd && (reg_addr == A_DATA);

  // transaction end: write pipes end on 1->0, read pipes on 0->1
  assign commit_in  = csr_wr && req_q && reg_wdata[B_REQ] && dir_q[sel_q]
                      && tx_q && !reg_wdata[B_TX] && !pkt_v[sel_q];
  assign commit_out = csr_wr && req_q && reg_wdata[B_REQ] && !dir_q[sel_q]
                      && !tx_q && reg_wdata[B_TX] && pkt_v[sel_q];
  assign flush_sel  = csr_wr && reg_wdata[B_CLR];
  assign fw_push_ok = data_wr && req_q && tx_q && dir_q[sel_q]
                      && !pkt_v[sel_q] && !full_v[sel_q];
  assign fw_touch   = data_rd && req_q && !dir_q[sel_q];
  assign fw_pop_ok  = fw_touch && pkt_v[sel_q] && !empty_v[sel_q];

  assign h_push_ok  = h_out_push && !dir_q[h_ep] && !pkt_v[h_ep] && !full_v[h_ep];
  assign h_end_ok   = h_out_end && !dir_q[h_ep] && !pkt_v[h_ep];
  assign h_pop_go   = h_in_pop && dir_q[h_ep] && pkt_v[h_ep] && !uflow_v[h_ep];
  assign h_pop_data = h_pop_go && !empty_v[h_ep];
  assign h_err      = h_in_pop && dir_q[h_ep] && uflow_v[h_ep];

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic on_sel, on_host;
    assign on_sel  = (sel_q == SELW'(i));
    assign on_host = (h_ep == SELW'(i));
    assign full_v[i]  = (cnt_a[i] == CW'(DEPTH));
    assign empty_v[i] = (cnt_a[i] == '0);
    assign rdy_v[i]   = dir_q[i] ? (!pkt_v[i] && empty_v[i]) : pkt_v[i];

    epf_buf #(.DW(DATA_W), .DEPTH(DEPTH)) u_buf (
      .clk        (clk),
      .rst        (rst || bus_rst),
      .flush      (flush_sel && on_sel),
      .is_in      (dir_q[i]),
      .push       ((fw_push_ok && on_sel) || (h_push_ok && on_host)),
      .wdata      ((h_push_ok && on_host) ? h_out_byte : reg_wdata),
      .pop        ((fw_pop_ok && on_sel) || (h_pop_go && on_host)),
      .host_end   (h_end_ok && on_host),
      .host_setup (h_out_setup),
      .commit_in  (commit_in && on_sel),
      .commit_out (commit_out && on_sel),
      .fw_touch   (fw_touch && on_sel),
      .rdata      (buf_rd[i]),
      .cnt        (cnt_a[i]),
      .pkt        (pkt_v[i]),
      .setup      (setup_v[i]),
      .zlp        (zlp_v[i]),
      .uflow      (uflow_v[i])
    );
  end

  // configuration and pipe direction: system reset only
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0; ien_q <= 1'b0; oen_q <= 1'b0; dir_q <= DIR_RESET;
    end else begin
      if (cfg_wr) begin
        sel_q <= reg_wdata[SELW-1:0];
        ien_q <= reg_wdata[C_IEN];
        oen_q <= reg_wdata[C_OEN];
      end
      if (dir_wr) dir_q <= reg_wdata[NUM_EP-1:0];
    end
  end

  // command/status writable bits: cleared by either reset
  always_ff @(posedge clk) begin
    if (rst || bus_rst) begin
      req_q <= 1'b0; tx_q <= 1'b0; tog_q <= 1'b0;
    end else if (csr_wr) begin
      req_q <= reg_wdata[B_REQ];
      tx_q  <= reg_wdata[B_TX];
      tog_q <= reg_wdata[B_TOG];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0; rd_data_q <= 1'b0; rsel_q <= '0; h_ep_q <= '0;
      h_in_valid <= 1'b0; h_in_err <= 1'b0;
      irq_iso_in <= 1'b0; irq_iso_out <= 1'b0;
    end else begin
      rd_data_q <= fw_pop_ok;
      rsel_q    <= sel_q;
      if (reg_rd) begin
        unique case (reg_addr)
          A_CSR:   rdata_q <= {1'b0, tog_q, zlp_v[sel_q], rdy_v[sel_q],
                               setup_v[sel_q], 1'b0, tx_q, req_q};
          A_CFG:   rdata_q <= DATA_W'({oen_q, ien_q, sel_q});
          A_DIR:   rdata_q <= DATA_W'(dir_q);
          default: rdata_q <= '0;
        endcase
      end
      h_ep_q      <= h_ep;
      h_in_valid  <= h_pop_data;
      h_in_err    <= h_err;
      irq_iso_in  <= ien_q && |(dir_q & rdy_v);
      irq_iso_out <= oen_q && |(~dir_q & pkt_v);
    end
  end

  assign reg_rdata = rd_data_q ? buf_rd[rsel_q] : rdata_q;
  assign h_in_byte = buf_rd[h_ep_q];
  assign h_data1   = tog_q;

  assert_busrst_clears_R1: assert property (@(posedge clk) disable iff (rst)
    bus_rst |=> !req_q && !tx_q && !tog_q && (pkt_v == '0));

  assert_err_excl_valid_R7: assert property (@(posedge clk) disable iff (rst)
    !(h_in_valid && h_in_err));

  assert_wrong_dir_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (h_in_pop && !dir_q[h_ep]) |=> !h_in_valid && !h_in_err);

  assert_toggle_out_R10: assert property (@(posedge clk) disable iff (rst || bus_rst)
    (csr_wr) |=> h_data1 == $past(reg_wdata[B_TOG]));
endmodule

// File: tb/sim_ep_fifo_ctrl.sv
module sim_ep_fifo_ctrl;
  logic       clk = 1'b0;
  logic       rst, bus_rst, reg_wr, reg_rd, h_out_push, h_out_end, h_out_setup, h_in_pop;
  logic [1:0] reg_addr, h_ep;
  logic [7:0] reg_wdata, h_out_byte, reg_rdata, h_in_byte;
  logic       h_in_valid, h_in_err, h_data1, irq_iso_in, irq_iso_out;
  int         checks = 0, errors = 0;
  logic [7:0] d;
  logic       v, e;

  always #10 clk = ~clk;

  ep_fifo_ctrl u0 (
    .clk(clk), .rst(rst), .bus_rst(bus_rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .h_ep(h_ep), .h_out_push(h_out_push), .h_out_byte(h_out_byte),
    .h_out_end(h_out_end), .h_out_setup(h_out_setup), .h_in_pop(h_in_pop),
    .h_in_valid(h_in_valid), .h_in_byte(h_in_byte), .h_in_err(h_in_err),
    .h_data1(h_data1), .irq_iso_in(irq_iso_in), .irq_iso_out(irq_iso_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] x);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = x;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] x);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; x = reg_rdata;
  endtask

  task automatic hpush(input logic [1:0] ep, input logic [7:0] b);
    @(negedge clk); h_out_push = 1'b1; h_ep = ep; h_out_byte = b;
    @(negedge clk); h_out_push = 1'b0;
  endtask

  task automatic hend(input logic [1:0] ep, input logic s);
    @(negedge clk); h_out_end = 1'b1; h_ep = ep; h_out_setup = s;
    @(negedge clk); h_out_end = 1'b0;
  endtask

  task automatic hpop(input logic [1:0] ep, output logic vo, output logic [7:0] bo, output logic eo);
    @(negedge clk); h_in_pop = 1'b1; h_ep = ep;
    @(negedge clk); h_in_pop = 1'b0; vo = h_in_valid; bo = h_in_byte; eo = h_in_err;
  endtask

  task automatic pulse_bus_rst();
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_rst = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    h_ep = '0; h_out_push = 1'b0; h_out_byte = '0; h_out_end = 1'b0; h_out_setup = 1'b0; h_in_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2: reset state
    rd(2'd0, d); chk("R2 csr after reset (EP1 ready)", d, 8'h10);
    rd(2'd2, d); chk("R2 pipe direction default", d, 8'h0D);
    rd(2'd1, d); chk("R2 config default", d, 8'h00);
    chk("R10 h_data1 after reset", h_data1, 0);

    // R10: toggle bit
    wr(2'd0, 8'h40); chk("R10 h_data1 set", h_data1, 1);
    rd(2'd0, d); chk("R10 toggle readback", d, 8'h50);
    wr(2'd0, 8'h00); chk("R10 h_data1 clear", h_data1, 0);

    // R4/R8: output pipe EP2, lengths 1..8
    wr(2'd1, 8'h01);
    for (int len = 1; len <= 8; len++) begin
      for (int i = 0; i < len; i++) hpush(2'd1, 8'(len * 16 + i));
      hend(2'd1, len[0]);
      rd(2'd0, d); chk("R4 ready after host packet", d, 8'h10 | (len[0] << 3));
      wr(2'd0, 8'h01);
      for (int i = 0; i < len; i++) begin
        rd(2'd3, d); chk("R4 output byte order", d, len * 16 + i);
      end
      wr(2'd0, 8'h03);
      wr(2'd0, 8'h00);
      rd(2'd0, d); chk("R8 setup kept after release, R4 not ready", d, len[0] << 3);
    end

    // R3: overfill
    for (int i = 0; i < 10; i++) hpush(2'd1, 8'(8'hC0 + i));
    hend(2'd1, 1'b0);
    wr(2'd0, 8'h01);
    for (int i = 0; i < 8; i++) begin
      rd(2'd3, d); chk("R3 stored bytes", d, 8'hC0 + i);
    end
    rd(2'd3, d); chk("R3 empty read returns zero", d, 8'h00);
    wr(2'd0, 8'h03); wr(2'd0, 8'h00);

    // R9: zero-length packet
    hend(2'd1, 1'b0);
    rd(2'd0, d); chk("R9 zlp set", d, 8'h30);
    wr(2'd0, 8'h01);
    rd(2'd0, d); chk("R9 zlp held until data read", d, 8'h31);
    rd(2'd3, d); chk("R9 zlp data read value", d, 8'h00);
    rd(2'd0, d); chk("R9 zlp cleared by read", d, 8'h11);
    wr(2'd0, 8'h03); wr(2'd0, 8'h00);

    // R5: input pipe EP1, lengths 1..8
    wr(2'd1, 8'h00);
    for (int len = 1; len <= 8; len++) begin
      wr(2'd0, 8'h03);
      for (int i = 0; i < len; i++) wr(2'd3, 8'((len * 7 + i * 3) & 255));
      wr(2'd0, 8'h01);
      wr(2'd0, 8'h00);
      rd(2'd0, d); chk("R5 not ready after commit", d, 8'h00);
      for (int i = 0; i < len; i++) begin
        hpop(2'd0, v, d, e);
        chk("R5 host pop valid", v, 1);
        chk("R5 host pop byte", d, (len * 7 + i * 3) & 255);
      end
      hpop(2'd0, v, d, e); chk("R5 drained pop quiet", {v, e}, 0);
      rd(2'd0, d); chk("R5 ready after drain", d, 8'h10);
    end

    // R7: clear then underrun
    wr(2'd0, 8'h03); wr(2'd3, 8'h99);
    wr(2'd0, 8'h04);
    rd(2'd0, d); chk("R7 ready after clear", d, 8'h10);
    hpop(2'd0, v, d, e); chk("R7 underrun err", {v, e}, 1);
    hpop(2'd0, v, d, e); chk("R7 underrun persists", {v, e}, 1);
    wr(2'd0, 8'h03); wr(2'd3, 8'h5A); wr(2'd0, 8'h01); wr(2'd0, 8'h00);
    hpop(2'd0, v, d, e); chk("R7 recovered valid/err", {v, e}, 2); chk("R7 recovered byte", d, 8'h5A);

    // R6: accesses with request low
    wr(2'd0, 8'h02); wr(2'd3, 8'h55);
    rd(2'd0, d); chk("R6 write without request ignored", d, 8'h12);
    wr(2'd0, 8'h00);
    hpop(2'd0, v, d, e); chk("R6 nothing committed", {v, e}, 0);
    hpush(2'd1, 8'h77); hend(2'd1, 1'b0);
    wr(2'd1, 8'h01);
    rd(2'd3, d); chk("R6 read without request", d, 8'h00);
    wr(2'd0, 8'h01);
    rd(2'd3, d); chk("R6 byte not consumed", d, 8'h77);
    wr(2'd0, 8'h03); wr(2'd0, 8'h00);

    // R11: wrong direction
    wr(2'd1, 8'h00);
    hpush(2'd0, 8'h11); hend(2'd0, 1'b1);
    rd(2'd0, d); chk("R11 input pipe untouched by host push", d, 8'h10);
    hpop(2'd1, v, d, e); chk("R11 pop on output pipe quiet", {v, e}, 0);

    // R12: interrupts
    hpush(2'd1, 8'h22); hend(2'd1, 1'b0);
    wr(2'd1, 8'h0C); @(negedge clk);
    chk("R12 irq_iso_in", irq_iso_in, 1);
    chk("R12 irq_iso_out", irq_iso_out, 1);
    wr(2'd1, 8'h00); @(negedge clk);
    chk("R12 irqs masked", {irq_iso_in, irq_iso_out}, 0);

    // R1: bus reset
    wr(2'd1, 8'h01); wr(2'd0, 8'h41);
    pulse_bus_rst();
    rd(2'd0, d); chk("R1 csr cleared", d, 8'h00);
    chk("R1 toggle cleared", h_data1, 0);
    wr(2'd2, 8'h0F);
    rd(2'd2, d); chk("R2 pipe direction writable", d, 8'h0F);
    pulse_bus_rst();
    rd(2'd2, d); chk("R1 pipe direction kept", d, 8'h0F);
    wr(2'd2, 8'h0D);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule